// File: doc/BRIEF.md
# TDM Frame Serializer

This block sends a 32-channel time-division-multiplexed frame as a serial bit stream, one bit per clock. Each frame has 32 timeslots of 8 bits, so it lasts 256 bit periods. At a 2.048 MHz bit clock this gives 8000 frames per second, with each channel carrying 64 kb/s. A free-running frame counter walks through every bit position. Its upper bits name the timeslot and its lower three bits give the bit position inside that slot.

The byte for each slot comes through a fetch port. The block shows on `fetch_slot` the number of the slot that will be loaded next. An external source answers combinationally on `fetch_byte`. During the last bit of every slot, the byte on `fetch_byte` is captured into a shift register. It then goes out most significant bit first during the following slot. A one-cycle frame marker is raised while the counter sits at its terminal count.

An optional zero-suppression mode replaces an all-zero byte with 00000010 before it is sent. This keeps ones density on the line.

Top module: `tdm_frame_tx`

## Requirements
- R1: While reset is asserted and right after it, `ser_data` is 0, `frame_mark` is 0 and `fetch_slot` is 1 (the counter is at 0, bit 0 of slot 0).
- R2: The frame counter advances once per clock and wraps after 256 counts, so every frame is exactly 256 clocks long.
- R3: `fetch_slot` equals the current slot number plus one, modulo 32. It changes only in the clock that begins a new slot, and it reads 0 during slot 31.
- R4: `frame_mark` is 1 for exactly one clock in every 256: the last bit of slot 31 (counter value 255).
- R5: The byte on `fetch_byte` during bit 7 of slot N is sent during slot N+1 (modulo 32), most significant bit first. Its first bit appears in the clock right after that capture.
- R6: With `zero_sup_en` at 1, a captured byte of 0x00 is sent as 0x02 (serial order 0,0,0,0,0,0,1,0). Any nonzero byte is sent unchanged.
- R7: With `zero_sup_en` at 0, a byte of 0x00 is sent as eight zero bits.
- R8: In the first frame after reset, slot 0 sends eight zero bits, because no byte has been captured yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_sup_en | input | 1 | Enables replacing an all-zero byte with 0x02 |
| fetch_byte | input | 8 | Byte for the slot named on fetch_slot |
| fetch_slot | output | 5 | Number of the slot to be loaded at the next capture |
| ser_data | output | 1 | Serial data, MSB first |
| frame_mark | output | 1 | One-clock strobe at the last bit of each frame |

## Verification
Several byte patterns are served through the fetch port:
- **Slot-dependent arithmetic values.** These expose any off-by-one in the slot that is fetched.
- **A mix with periodic zero bytes.** This separates the zero-suppression path from the plain path.
- **An all-zero pattern with suppression on and off.** This shows that the substitute byte appears only when the mode is enabled.

A reset in the middle of a frame checks that the counter, the shift register and the frame marker all restart together. It also checks that the first slot after reset is silent.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned DEF_NUM_SLOTS  = 32;
  localparam int unsigned DEF_SLOT_BITS  = 8;
  // bit position set in the substitute for an all-zero byte
  localparam int unsigned ZS_FILL_BITPOS = 1;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] next_slot,
  output logic              load_en,
  output logic              frame_end
);
  localparam int unsigned CNT_W = SLOT_W + BIT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    load_en   = &cnt_q[BIT_W-1:0];
    frame_end = &cnt_q;
    next_slot = cnt_q[CNT_W-1:BIT_W] + SLOT_W'(1);
  end
endmodule

// File: rtl/tdm_zero_sub.sv
module tdm_zero_sub #(
  parameter int unsigned W = 8
) (
  input  logic         enable,
  input  logic [W-1:0] raw,
  output logic [W-1:0] coded
);
  localparam logic [W-1:0] FILL = W'(1) << tdm_pkg::ZS_FILL_BITPOS;

  always_comb begin
    if (enable && (raw == '0)) coded = FILL;
    else                       coded = raw;
  end
endmodule

// File: rtl/tdm_piso.sv
module tdm_piso #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par_in,
  output logic         ser_out,
  output logic [W-1:0] shreg
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    if (load) sh_d = par_in;
    else      sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_out = sh_q[W-1];
  assign shreg   = sh_q;
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int unsigned NUM_SLOTS = tdm_pkg::DEF_NUM_SLOTS,
  parameter int unsigned SLOT_BITS = tdm_pkg::DEF_SLOT_BITS,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 zero_sup_en,
  input  logic [SLOT_BITS-1:0] fetch_byte,
  output logic [SLOT_W-1:0]    fetch_slot,
  output logic                 ser_data,
  output logic                 frame_mark
);
  logic                 load_en;
  logic [SLOT_BITS-1:0] coded_byte;
  logic [SLOT_BITS-1:0] shreg;

  tdm_slot_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_slot (fetch_slot),
    .load_en   (load_en),
    .frame_end (frame_mark)
  );

  tdm_zero_sub #(.W(SLOT_BITS)) zsub_i (
    .enable (zero_sup_en),
    .raw    (fetch_byte),
    .coded  (coded_byte)
  );

  tdm_piso #(.W(SLOT_BITS)) piso_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_en),
    .par_in  (coded_byte),
    .ser_out (ser_data),
    .shreg   (shreg)
  );
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              zero_sup_en,
  input logic [W-1:0]      fetch_byte,
  input logic [SLOT_W-1:0] fetch_slot,
  input logic              ser_data,
  input logic              frame_mark,
  input logic              load_en,
  input logic [W-1:0]      coded_byte,
  input logic [W-1:0]      shreg
);
  localparam int unsigned CW = SLOT_W + BIT_W;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + CW'(1);
  end

  assert_mark_at_terminal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark == (cyc == {CW{1'b1}}));

  assert_mark_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> !frame_mark);

  assert_mark_fetch_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> (fetch_slot == '0));

  assert_slot_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc[BIT_W-1:0] != '0) |-> $stable(fetch_slot));

  assert_load_on_last_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (cyc[BIT_W-1:0] == {BIT_W{1'b1}}));

  assert_first_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ser_data == $past(coded_byte[W-1])));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (ser_data == $past(shreg[W-2])));

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && zero_sup_en && (fetch_byte == '0)) |=> (shreg == W'(2)));

  assert_zero_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !zero_sup_en && (fetch_byte == '0)) |=> (shreg == '0));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .W(SLOT_BITS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .zero_sup_en (zero_sup_en),
  .fetch_byte  (fetch_byte),
  .fetch_slot  (fetch_slot),
  .ser_data    (ser_data),
  .frame_mark  (frame_mark),
  .load_en     (load_en),
  .coded_byte  (coded_byte),
  .shreg       (shreg)
);

// File: tb/tdm_frame_tx_tb.sv
module tdm_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       zero_sup_en;
  logic [7:0] fetch_byte;
  logic [4:0] fetch_slot;
  logic       ser_data;
  logic       frame_mark;

  int n_checks = 0;
  int n_fail   = 0;
  int mode     = 0;
  bit done     = 1'b0;

  // reference model state
  int       m_cnt;
  bit [7:0] m_word;
  string    m_tag;
  bit       first_slot;

  always #5 clk = ~clk;

  tdm_frame_tx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .zero_sup_en (zero_sup_en),
    .fetch_byte  (fetch_byte),
    .fetch_slot  (fetch_slot),
    .ser_data    (ser_data),
    .frame_mark  (frame_mark)
  );

  function automatic bit [7:0] pattern(int m, int slot);
    case (m)
      0:       return 8'((slot * 37 + 11) % 256);
      1:       return (slot % 3 == 0) ? 8'h00 : 8'(~slot);
      2:       return 8'h00;
      default: return 8'(slot) ^ 8'hA5;
    endcase
  endfunction

  // external byte source answering the fetch port
  always_comb fetch_byte = pattern(mode, int'(fetch_slot));

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // model update on every active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_word = 8'h00; m_tag = "R8"; first_slot = 1'b1;
    end else begin
      if (m_cnt % 8 == 7) begin
        int nxt;
        bit [7:0] raw;
        nxt = (m_cnt / 8 + 1) % 32;
        raw = pattern(mode, nxt);
        if (raw == 8'h00 && zero_sup_en) begin m_word = 8'h02; m_tag = "R6"; end
        else if (raw == 8'h00)           begin m_word = 8'h00; m_tag = "R7"; end
        else                             begin m_word = raw;   m_tag = "R5"; end
        first_slot = 1'b0;
      end else begin
        m_word = m_word << 1;
      end
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(first_slot ? "R8" : m_tag, int'(ser_data), int'(m_word[7]));
      check("R4", int'(frame_mark), (m_cnt == 255) ? 1 : 0);
      check("R3", int'(fetch_slot), (m_cnt / 8 + 1) % 32);
      if (m_cnt == 0) check("R2 frame start slot", int'(fetch_slot), 1);
    end
  end

  task automatic run_frames(int m, bit zs, int frames);
    mode = m; zero_sup_en = zs;
    repeat (frames * 256) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; zero_sup_en = 1'b0; mode = 0;
    repeat (3) @(negedge clk);
    check("R1 ser", int'(ser_data), 0);
    check("R1 mark", int'(frame_mark), 0);
    check("R1 slot", int'(fetch_slot), 1);
    #2 rst_n = 1'b1;
    run_frames(0, 1'b0, 2);
    run_frames(1, 1'b1, 2);
    run_frames(2, 1'b1, 1);
    run_frames(2, 1'b0, 1);
    run_frames(1, 1'b0, 1);
    repeat (100) @(negedge clk);
    // reset in mid-frame
    #2 rst_n = 1'b0;
    @(negedge clk);
    check("R1 ser mid", int'(ser_data), 0);
    check("R1 mark mid", int'(frame_mark), 0);
    check("R1 slot mid", int'(fetch_slot), 1);
    #2 rst_n = 1'b1;
    run_frames(3, 1'b1, 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule